// File: doc/BRIEF.md
# Comparator Offset Trim Calibration Controller

This block drives the repeated trim search that cancels the threshold offset of one pixel comparator. It holds a digital trim code, which analog circuitry outside the block turns into a shift of the comparator's reference. During calibration, the surrounding logic applies a fixed test charge once per calibration cycle. It then reports whether the comparator fired and marks that report with a one-cycle strobe. The controller responds by moving the trim code by one step.

Two search modes are available. In the two-way mode the code starts at mid-scale. A fire moves it down and a miss moves it up, so the code settles into a one-step dither around the balance point. In the one-way mode the code starts at full scale, which is above any offset the pixel can have. A fire moves it down and a miss leaves it unchanged, so the code stops at the highest value that no longer fires.

The number of strobes to process is supplied with the start command. When that many strobes have been handled, the block raises its done flag. From then on the code is frozen, so it stays put for the whole bunch train that follows.

Top module: `cmp_trim_cal`

## Requirements
- R1: While reset is applied, and for the first cycles after it, the trim code equals mid-scale (128 with 8 bits), and both busy and done are low.
- R2: A start pulse while not busy raises busy and clears done on the next cycle. In that same cycle it loads the trim code: 128 when mode_i is 0 (two-way) and 255 when mode_i is 1 (one-way).
- R3: In two-way mode, each strobe accepted while busy moves the trim code one cycle later. It moves down by one when fire_i is 1 and up by one when fire_i is 0.
- R4: In one-way mode, an accepted strobe with fire_i at 1 lowers the trim code by one. An accepted strobe with fire_i at 0 leaves it unchanged.
- R5: The trim code saturates: a down step at 0 stays at 0, an up step at 255 stays at 255, and the code never wraps.
- R6: After exactly cycles_i accepted strobes, busy falls and done rises in the cycle after the last step. A count of 0 gives done one cycle after busy rose, with the code still at its start value.
- R7: While busy is low, strobe_i and fire_i have no effect on the trim code.
- R8: A start pulse while busy is ignored. The code, the remaining count and the mode all continue unchanged.
- R9: Done stays high until the next start pulse is accepted.
- R10: mode_i and cycles_i are sampled only when a start is accepted. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse for a calibration run |
| mode_i | input | 1 | 0 = two-way search, 1 = one-way search |
| cycles_i | input | CNT_W | Number of strobes to process in the run |
| strobe_i | input | 1 | Marks the cycle in which fire_i is valid |
| fire_i | input | 1 | Comparator result for the current test pulse |
| trim_o | output | TRIM_W | Trim code toward the reference shifter |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, code frozen |

## Verification
The bench closes the loop with a model comparator that fires whenever the code exceeds a chosen offset, and it checks the code after every strobe. Runs with offsets outside the code range drive the code into both rails. A design that wraps would jump from 0 to 255 or from 255 to 0 there. The bench also pulses start, and changes the mode and the count, in the middle of a run. A design that restarts or re-samples would then reload the code or end early. A zero-count run and strobes sent after done target a design that steps a frozen code or miscounts by one.

// File: rtl/cmp_trim_pkg.sv
package cmp_trim_pkg;

  typedef enum logic {
    CAL_TWO_WAY = 1'b0,
    CAL_ONE_WAY = 1'b1
  } cal_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/cal_cycle_seq.sv
module cal_cycle_seq
  import cmp_trim_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] cycles_i,
  input  logic             strobe_i,
  output logic             load_o,
  output logic             step_o,
  output cal_mode_e        mode_o,
  output logic             busy_o,
  output logic             done_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  cal_mode_e        mode_q, mode_d;
  logic             rem_zero;

  assign rem_zero = (rem_q == '0);
  assign load_o   = start_i && (state_q != SEQ_RUN);
  assign step_o   = (state_q == SEQ_RUN) && strobe_i && !rem_zero;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    mode_d  = mode_q;
    unique case (state_q)
      SEQ_RUN: begin
        if (rem_zero)      state_d = SEQ_DONE;
        else if (strobe_i) rem_d   = rem_q - 1'b1;
      end
      default: begin
        if (start_i) begin
          state_d = SEQ_RUN;
          rem_d   = cycles_i;
          mode_d  = cal_mode_e'(mode_i);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      mode_q  <= CAL_TWO_WAY;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      mode_q  <= mode_d;
    end
  end

  assign mode_o = mode_q;
  assign busy_o = (state_q == SEQ_RUN);
  assign done_o = (state_q == SEQ_DONE);

  // R8 and R10: a start or a new mode during a run touches neither the count nor the mode
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !strobe_i && !rem_zero |=> $stable(rem_q) && $stable(mode_q));

  // R6: an exhausted count ends the run on the next edge
  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rem_zero |=> done_o && !busy_o);

  // R9: done holds until a start arrives
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

endmodule

// File: rtl/cal_trim_stepper.sv
module cal_trim_stepper
  import cmp_trim_pkg::*;
#(
  parameter int TRIM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              load_mode_i,
  input  logic              step_i,
  input  cal_mode_e         mode_i,
  input  logic              fire_i,
  output logic [TRIM_W-1:0] trim_o
);

  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};
  localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);

  logic [TRIM_W-1:0] trim_q, trim_d;
  logic              trim_en;
  logic              at_max, at_min;

  assign at_max  = (trim_q == TRIM_MAX);
  assign at_min  = (trim_q == '0);
  assign trim_en = load_i || step_i;

  always_comb begin
    trim_d = trim_q;
    if (load_i) begin
      trim_d = load_mode_i ? TRIM_MAX : TRIM_MID;
    end else if (step_i) begin
      if (fire_i) begin
        if (!at_min) trim_d = trim_q - 1'b1;
      end else if (mode_i == CAL_TWO_WAY) begin
        if (!at_max) trim_d = trim_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trim_q <= TRIM_MID;
    else if (trim_en) trim_q <= trim_d;
  end

  assign trim_o = trim_q;

  // R5: no wrap from the top rail to zero
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    at_max |=> trim_q != '0);

  // R5: no wrap from zero to the top rail unless a one-way load occurs
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    at_min && !(load_i && load_mode_i) |=> trim_q != TRIM_MAX);

  // R4: a one-way miss leaves the code alone
  a_r4_hold_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && (mode_i == CAL_ONE_WAY) && !fire_i |=> $stable(trim_q));

endmodule

// File: rtl/cmp_trim_cal.sv
module cmp_trim_cal
  import cmp_trim_pkg::*;
#(
  parameter int TRIM_W = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  cycles_i,
  input  logic              strobe_i,
  input  logic              fire_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              busy_o,
  output logic              done_o
);

  logic      rst_n_s;
  logic      load_w, step_w;
  cal_mode_e run_mode_w;

  cal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cal_cycle_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .cycles_i (cycles_i),
    .strobe_i (strobe_i),
    .load_o   (load_w),
    .step_o   (step_w),
    .mode_o   (run_mode_w),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  cal_trim_stepper #(.TRIM_W(TRIM_W)) u_trim (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .load_i      (load_w),
    .load_mode_i (mode_i),
    .step_i      (step_w),
    .mode_i      (run_mode_w),
    .fire_i      (fire_i),
    .trim_o      (trim_o)
  );

  // R7: the code is frozen whenever no run is active and no start arrives
  a_r7_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o && !start_i |=> $stable(trim_o));

  // R3: the code moves by at most one step per cycle during a run
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_o |=> (int'(trim_o) - int'($past(trim_o)) <= 1) &&
               (int'(trim_o) - int'($past(trim_o)) >= -1));

  // R4: a one-way run never raises the code
  a_r4_down_only: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_o && (run_mode_w == CAL_ONE_WAY) |=> trim_o <= $past(trim_o));

  // R2: an accepted start raises busy and clears done
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o && start_i |=> busy_o && !done_o);

  // R6: busy and done are never high together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(busy_o && done_o));

endmodule

// File: tb/cmp_trim_cal_test.sv
module cmp_trim_cal_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, mode_i, strobe_i, fire_i;
  logic [9:0] cycles_i;
  logic [7:0] trim_o;
  logic       busy_o, done_o;

  int total = 0;
  int bad   = 0;
  int exp_q[$];
  logic prev_done = 1'b0;

  always #5 clk = ~clk;

  cmp_trim_cal uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .cycles_i(cycles_i), .strobe_i(strobe_i), .fire_i(fire_i),
    .trim_o(trim_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: on each rising done, compare the final code with the scoreboard
  always @(negedge clk) begin
    if (done_o && !prev_done) begin
      if (exp_q.size() == 0) check("R6 unexpected done", 1, 0);
      else check("R6 final code", int'(trim_o), exp_q.pop_front());
    end
    prev_done <= done_o;
  end

  // driver: one run against a model comparator that fires when code > offset
  task automatic run_cal(input bit md, input int n, input int offset,
                         input bit gap, input bit poke);
    int exp;
    bit fire_m;
    @(negedge clk);
    start_i = 1'b1; mode_i = md; cycles_i = 10'(n);
    @(negedge clk);
    start_i = 1'b0;
    exp = md ? 255 : 128;
    check("R2 busy", int'(busy_o), 1);
    check("R2 done cleared", int'(done_o), 0);
    check("R2 start code", int'(trim_o), exp);
    // R10: change the sampled inputs mid-run
    mode_i = ~md; cycles_i = 10'd1;
    for (int i = 0; i < n; i++) begin
      if (gap) begin
        @(negedge clk);
        check("R3 no step without strobe", int'(trim_o), exp);
      end
      strobe_i = 1'b1;
      fire_i   = (int'(trim_o) > offset);
      fire_m   = (exp > offset);
      if (poke && i == 1) begin
        start_i = 1'b1;  // R8: ignored while busy
        mode_i  = ~md;
        cycles_i = 10'd2;
      end
      if (fire_m) exp = (exp > 0) ? exp - 1 : 0;
      else if (!md) exp = (exp < 255) ? exp + 1 : 255;
      @(negedge clk);
      strobe_i = 1'b0;
      start_i  = 1'b0;
      check(md ? "R4 one-way step" : "R3 two-way step", int'(trim_o), exp);
    end
    exp_q.push_back(exp);
    @(negedge clk);
    check("R6 done after count", int'(done_o), 1);
    check("R6 busy falls", int'(busy_o), 0);
    // R7: strobes after done are ignored
    for (int k = 0; k < 3; k++) begin
      strobe_i = 1'b1;
      fire_i   = k[0];
      @(negedge clk);
    end
    strobe_i = 1'b0;
    check("R7 frozen after done", int'(trim_o), exp);
    check("R9 done held", int'(done_o), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; cycles_i = '0;
    strobe_i = 1'b0; fire_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(trim_o), 128);
    check("R1 reset busy", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 code after release", int'(trim_o), 128);
    check("R1 done after release", int'(done_o), 0);
    // R7: strobes while idle
    strobe_i = 1'b1; fire_i = 1'b1;
    repeat (2) @(negedge clk);
    strobe_i = 1'b0;
    check("R7 idle strobes ignored", int'(trim_o), 128);

    run_cal(1'b0, 40, 100, 1'b0, 1'b1);   // R3 dither, R8 poke
    run_cal(1'b0, 30, 200, 1'b1, 1'b0);   // R3 climb with gaps
    run_cal(1'b0, 140, 300, 1'b0, 1'b0);  // R5 top rail
    run_cal(1'b0, 140, -1, 1'b0, 1'b0);   // R5 bottom rail
    run_cal(1'b1, 250, 50, 1'b0, 1'b1);   // R4 descend then hold
    run_cal(1'b1, 20, 300, 1'b1, 1'b0);   // R4 never fires
    run_cal(1'b1, 260, -1, 1'b0, 1'b0);   // R5 one-way to zero
    run_cal(1'b0, 0, 10, 1'b0, 1'b0);     // R6 zero count

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule